// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block runs single accesses to an asynchronous static memory or ROM. An internal master presents a request with a write flag, an address and write data. The sequencer then drives the external address, a chip select for each bank, output enable, write enable and the write data through a fixed order of phases. The phases are address setup, chip-select setup, the strobe window, chip-select hold and address hold. Each phase has its own programmable length, counted in clock cycles. Read data is returned together with a single-cycle completion pulse.

The upper address bits pick one of several banks. Each bank has its own static configuration: a six-field timing word, a page-mode enable and a data-width select of one or two bytes. With page mode on, a read fetches four items under one chip-select window. Only the low two address bits advance between items, and output enable stays low for the whole window. The timing of a bank is copied into the sequencer when its request is accepted, so configuration changes never disturb an access that is already running.

Top module: `srom_bank_seq`

## Requirements
- R1: Bank b's timing word occupies `cfg_timing[25b+24:25b]`. Inside the word, address setup is bits [3:0], chip-select setup [7:4], strobe length [12:8], chip-select hold [16:13], address hold [20:17] and page item length [24:21]. The bank is given by the top two bits of `req_addr`.
- R2: After a request is accepted, the address is driven with every chip select high for exactly address-setup cycles.
- R3: The bank's chip select then goes low for exactly chip-select-setup cycles before the strobe falls.
- R4: A single-item access holds its strobe low for exactly strobe-length + 1 cycles.
- R5: After the strobe rises, chip select stays low for chip-select-hold cycles and then is high for address-hold cycles. `done` is then high for exactly one cycle, and `req_ready` returns high in the following cycle.
- R6: A page-mode read moves four items. The first item lasts strobe-length + 1 cycles and each later item lasts page-length + 1 cycles, with chip select and output enable held low. For item k, the low two address bits equal the request's low bits + k modulo 4, and the upper bits are unchanged.
- R7: Item k is captured on the last strobe cycle of that item and appears on `rd_data[16k+15:16k]`. Items that were not fetched read zero. The value is valid while `done` is high. `rd_data` is cleared when a request is accepted.
- R8: When a bank's `cfg_wide` bit is 0 (one-byte width), bits [15:8] of each captured item and of `mem_dout` are zero. When the bit is 1, all 16 bits are used.
- R9: A write uses `mem_we_n` as its strobe and keeps `mem_oe_n` high. `mem_dout_en` is high exactly while chip select is low. A write always moves one item, even when page mode is enabled.
- R10: Only the addressed bank's chip select goes low, and at most one chip select is low at any time.
- R11: A request presented while `req_ready` is low is ignored and never starts an access.
- R12: A zero setup or hold field adds no cycles. With all fields zero, one strobe cycle follows acceptance directly and `done` comes in the next cycle.
- R13: During and after reset, all chip selects, `mem_oe_n` and `mem_we_n` are high, `mem_dout_en` and `done` are low, `req_ready` is high and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, accepted when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Bank index in the top bits, memory address below |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle and able to accept |
| rd_data | output | 64 | Four read items, item k at bits [16k+15:16k] |
| done | output | 1 | One-cycle completion pulse |
| cfg_timing | input | NUM_BANKS*25 | Packed per-bank timing words |
| cfg_page | input | NUM_BANKS | Per-bank four-item page mode enable |
| cfg_wide | input | NUM_BANKS | Per-bank width: 0 one byte, 1 two bytes |
| mem_addr | output | ADDR_W-log2(NUM_BANKS) | External address |
| mem_cs_n | output | NUM_BANKS | Active-low chip select, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 16 | Write data to memory |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | 16 | Read data from memory |

## Verification
The bench uses the default build: four banks and a 12-bit request address, which leaves a 10-bit memory address. With four banks the top two address bits reach every bank. This lets the bench hold configurations that differ per bank at the same time, and it makes chip-select exclusivity and per-bank latching observable. The 5-bit phase counter in that build covers the full 31-cycle strobe field and the 15-cycle page field. Directed cases therefore reach the maximum-length page read, the all-zero fastest access, and the wrap of the low address bits.

// File: rtl/srom_seq_pkg.sv
package srom_seq_pkg;

    localparam int unsigned SHORT_W    = 4;
    localparam int unsigned ACC_W      = 5;
    localparam int unsigned TIMING_W   = 5 * SHORT_W + ACC_W;
    localparam int unsigned PAGE_BEATS = 4;
    localparam int unsigned BEAT_W     = $clog2(PAGE_BEATS);
    localparam int unsigned DATA_W     = 16;
    localparam int unsigned BYTE_W     = 8;

    // Field order is fixed; lowest field first in the packed word.
    typedef struct packed {
        logic [SHORT_W-1:0] page_cyc;
        logic [SHORT_W-1:0] addr_hold;
        logic [SHORT_W-1:0] cs_hold;
        logic [ACC_W-1:0]   acc_cyc;
        logic [SHORT_W-1:0] cs_setup;
        logic [SHORT_W-1:0] addr_setup;
    } bank_timing_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ASETUP = 3'd1,
        PH_CSETUP = 3'd2,
        PH_ACCESS = 3'd3,
        PH_PAGE   = 3'd4,
        PH_CHOLD  = 3'd5,
        PH_AHOLD  = 3'd6,
        PH_DONE   = 3'd7
    } phase_e;

endpackage

// File: rtl/srom_cfg_select.sv
module srom_cfg_select
    import srom_seq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS*TIMING_W-1:0] cfg_timing,
    input  logic [NUM_BANKS-1:0]          cfg_page,
    input  logic [NUM_BANKS-1:0]          cfg_wide,
    input  logic [BANK_W-1:0]             bank_sel,
    output bank_timing_t                  sel_timing,
    output logic                          sel_page,
    output logic                          sel_wide
);

    bank_timing_t timing_tbl [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
        assign timing_tbl[b] = cfg_timing[b*TIMING_W +: TIMING_W];
    end

    assign sel_timing = timing_tbl[bank_sel];
    assign sel_page   = cfg_page[bank_sel];
    assign sel_wide   = cfg_wide[bank_sel];

endmodule

// File: rtl/srom_phase_counter.sv
module srom_phase_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (cnt_q.cnt != '0) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q.cnt == '0);

    // A new phase is only loaded once the previous one ran out.
    assert_load_after_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

    // A running count moves down by exactly one each cycle.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired && !load) |=> (cnt_q.cnt == $past(cnt_q.cnt) - 1'b1));

endmodule

// File: rtl/srom_bank_seq.sv
module srom_bank_seq
    import srom_seq_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 4,
    parameter int unsigned ADDR_W      = 12,
    localparam int unsigned BANK_W     = $clog2(NUM_BANKS),
    localparam int unsigned MEM_ADDR_W = ADDR_W - BANK_W,
    localparam int unsigned RD_W       = PAGE_BEATS * DATA_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          req_ready,
    output logic [RD_W-1:0]               rd_data,
    output logic                          done,
    input  logic [NUM_BANKS*TIMING_W-1:0] cfg_timing,
    input  logic [NUM_BANKS-1:0]          cfg_page,
    input  logic [NUM_BANKS-1:0]          cfg_wide,
    output logic [MEM_ADDR_W-1:0]         mem_addr,
    output logic [NUM_BANKS-1:0]          mem_cs_n,
    output logic                          mem_oe_n,
    output logic                          mem_we_n,
    output logic [DATA_W-1:0]             mem_dout,
    output logic                          mem_dout_en,
    input  logic [DATA_W-1:0]             mem_din
);

    typedef struct packed {
        phase_e                  ph;
        logic [BANK_W-1:0]       bank;
        logic [MEM_ADDR_W-1:0]   addr;
        logic                    wr;
        logic [DATA_W-1:0]       wdata;
        bank_timing_t            tm;
        logic                    page;
        logic                    wide;
        logic [BEAT_W-1:0]       beat;
        logic [RD_W-1:0]         rdata;
    } seq_state_t;

    seq_state_t   seq_d, seq_q;
    bank_timing_t sel_tm;
    bank_timing_t tm_eff;
    logic         sel_page, sel_wide;
    logic         ph_expired;
    logic         ph_load;
    logic [ACC_W-1:0] ph_len;
    logic [DATA_W-1:0] din_masked;
    logic         cs_active, strobe, cs_any_low;
    logic [NUM_BANKS-1:0] bank_oh;

    srom_cfg_select #(
        .NUM_BANKS (NUM_BANKS)
    ) u_cfg_select (
        .cfg_timing (cfg_timing),
        .cfg_page   (cfg_page),
        .cfg_wide   (cfg_wide),
        .bank_sel   (req_addr[ADDR_W-1 -: BANK_W]),
        .sel_timing (sel_tm),
        .sel_page   (sel_page),
        .sel_wide   (sel_wide)
    );

    srom_phase_counter #(
        .CNT_W (ACC_W)
    ) u_phase_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_len),
        .expired  (ph_expired)
    );

    // Counter preload for a phase: the phase lasts preload + 1 cycles.
    function automatic logic [ACC_W-1:0] phase_preload(phase_e p, bank_timing_t t);
        logic [ACC_W-1:0] v;
        case (p)
            PH_ASETUP: v = ACC_W'(t.addr_setup) - ACC_W'(1);
            PH_CSETUP: v = ACC_W'(t.cs_setup)   - ACC_W'(1);
            PH_ACCESS: v = t.acc_cyc;
            PH_PAGE:   v = ACC_W'(t.page_cyc);
            PH_CHOLD:  v = ACC_W'(t.cs_hold)    - ACC_W'(1);
            PH_AHOLD:  v = ACC_W'(t.addr_hold)  - ACC_W'(1);
            default:   v = '0;
        endcase
        return v;
    endfunction

    // First phase after the strobe window, skipping zero-length holds.
    function automatic phase_e tail_phase(bank_timing_t t);
        if (t.cs_hold != '0)        return PH_CHOLD;
        else if (t.addr_hold != '0) return PH_AHOLD;
        else                        return PH_DONE;
    endfunction

    assign tm_eff     = (seq_q.ph == PH_IDLE) ? sel_tm : seq_q.tm;
    assign din_masked = seq_q.wide ? mem_din
                                   : {{(DATA_W-BYTE_W){1'b0}}, mem_din[BYTE_W-1:0]};

    always_comb begin
        seq_d   = seq_q;
        ph_load = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.bank  = req_addr[ADDR_W-1 -: BANK_W];
                    seq_d.addr  = req_addr[MEM_ADDR_W-1:0];
                    seq_d.wr    = req_write;
                    seq_d.wdata = req_wdata;
                    seq_d.tm    = sel_tm;
                    seq_d.page  = sel_page;
                    seq_d.wide  = sel_wide;
                    seq_d.beat  = '0;
                    seq_d.rdata = '0;
                    ph_load     = 1'b1;
                    if (sel_tm.addr_setup != '0)    seq_d.ph = PH_ASETUP;
                    else if (sel_tm.cs_setup != '0) seq_d.ph = PH_CSETUP;
                    else                            seq_d.ph = PH_ACCESS;
                end
            end
            PH_ASETUP: begin
                if (ph_expired) begin
                    ph_load  = 1'b1;
                    seq_d.ph = (seq_q.tm.cs_setup != '0) ? PH_CSETUP : PH_ACCESS;
                end
            end
            PH_CSETUP: begin
                if (ph_expired) begin
                    ph_load  = 1'b1;
                    seq_d.ph = PH_ACCESS;
                end
            end
            PH_ACCESS, PH_PAGE: begin
                if (ph_expired) begin
                    if (!seq_q.wr) begin
                        seq_d.rdata[int'(seq_q.beat)*DATA_W +: DATA_W] = din_masked;
                    end
                    ph_load = 1'b1;
                    if (seq_q.page && !seq_q.wr &&
                        seq_q.beat != BEAT_W'(PAGE_BEATS-1)) begin
                        seq_d.beat = seq_q.beat + 1'b1;
                        seq_d.ph   = PH_PAGE;
                    end else begin
                        seq_d.ph = tail_phase(seq_q.tm);
                    end
                end
            end
            PH_CHOLD: begin
                if (ph_expired) begin
                    ph_load  = 1'b1;
                    seq_d.ph = (seq_q.tm.addr_hold != '0) ? PH_AHOLD : PH_DONE;
                end
            end
            PH_AHOLD: begin
                if (ph_expired) begin
                    ph_load  = 1'b1;
                    seq_d.ph = PH_DONE;
                end
            end
            PH_DONE: begin
                seq_d.ph = PH_IDLE;
            end
            default: begin
                seq_d.ph = PH_IDLE;
            end
        endcase
        ph_len = phase_preload(seq_d.ph, tm_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.ph <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Output decode from registered state only.
    always_comb begin
        bank_oh               = '0;
        bank_oh[seq_q.bank]   = 1'b1;
    end

    assign cs_active = (seq_q.ph == PH_CSETUP) || (seq_q.ph == PH_ACCESS) ||
                       (seq_q.ph == PH_PAGE)   || (seq_q.ph == PH_CHOLD);
    assign strobe    = (seq_q.ph == PH_ACCESS) || (seq_q.ph == PH_PAGE);

    assign mem_cs_n    = cs_active ? ~bank_oh : '1;
    assign mem_oe_n    = ~(strobe & ~seq_q.wr);
    assign mem_we_n    = ~(strobe &  seq_q.wr);
    assign mem_dout_en = cs_active & seq_q.wr;
    assign mem_dout    = seq_q.wide ? seq_q.wdata
                                    : {{(DATA_W-BYTE_W){1'b0}}, seq_q.wdata[BYTE_W-1:0]};
    assign mem_addr    = {seq_q.addr[MEM_ADDR_W-1:BEAT_W],
                          seq_q.addr[BEAT_W-1:0] + seq_q.beat};
    assign req_ready   = (seq_q.ph == PH_IDLE);
    assign done        = (seq_q.ph == PH_DONE);
    assign rd_data     = seq_q.rdata;

    assign cs_any_low  = (mem_cs_n != '1);

    assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    assert_strobe_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> cs_any_low);

    assert_oe_we_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(done));

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_any_low && $past(cs_any_low) && seq_q.ph != PH_PAGE) |-> $stable(mem_addr));

    assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !done) |=> !req_ready);

endmodule

// File: tb/sim_srom_bank_seq.sv
module sim_srom_bank_seq;
    import srom_seq_pkg::*;

    localparam int unsigned NB  = 4;
    localparam int unsigned AW  = 12;
    localparam int unsigned MAW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr  = '0;
    logic [15:0]       req_wdata = '0;
    logic              req_ready;
    logic [63:0]       rd_data;
    logic              done;
    logic [NB*25-1:0]  cfg_timing;
    logic [NB-1:0]     cfg_page;
    logic [NB-1:0]     cfg_wide;
    logic [MAW-1:0]    mem_addr;
    logic [NB-1:0]     mem_cs_n;
    logic              mem_oe_n, mem_we_n;
    logic [15:0]       mem_dout;
    logic              mem_dout_en;
    logic [15:0]       mem_din;

    logic [3:0] c_as [NB];
    logic [3:0] c_cs [NB];
    logic [4:0] c_acc[NB];
    logic [3:0] c_ch [NB];
    logic [3:0] c_ah [NB];
    logic [3:0] c_pg [NB];

    int checks = 0;
    int failures = 0;

    for (genvar b = 0; b < NB; b++) begin : g_cfg
        assign cfg_timing[b*25 +: 25] = {c_pg[b], c_ah[b], c_ch[b], c_acc[b], c_cs[b], c_as[b]};
    end

    function automatic logic [15:0] model_word(int b, logic [MAW-1:0] a);
        return (16'(a) * 16'h9E37) ^ 16'h5A3C ^ 16'(b << 12);
    endfunction

    function automatic int low_bank(logic [NB-1:0] csn);
        for (int i = 0; i < NB; i++) if (!csn[i]) return i;
        return 0;
    endfunction

    assign mem_din = mem_oe_n ? 16'h0000 : model_word(low_bank(mem_cs_n), mem_addr);

    srom_bank_seq #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_data(rd_data), .done(done),
        .cfg_timing(cfg_timing), .cfg_page(cfg_page), .cfg_wide(cfg_wide),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_bank(input int b, input int as, input int cs, input int acc,
                            input int ch, input int ah, input int pg, input bit pe, input bit we);
        c_as[b] = 4'(as); c_cs[b] = 4'(cs); c_acc[b] = 5'(acc);
        c_ch[b] = 4'(ch); c_ah[b] = 4'(ah); c_pg[b] = 4'(pg);
        cfg_page[b] = pe; cfg_wide[b] = we;
    endtask

    // Runs one access, measures every phase at the pins and checks it.
    task automatic do_access(input int b, input bit wr, input logic [MAW-1:0] a,
                             input logic [15:0] wd, input bit poke, input string tag);
        int n_pre = 0, n_csu = 0, n_str = 0, n_csh = 0, n_ah = 0, ph = 0, guard = 0;
        int acc1, pg1, exp_str, beat;
        bit addr_bad = 0, cs_bad = 0, wr_bad = 0, seen_done = 0, pmode, any_cs, stb;
        logic [63:0] exp_rd;
        logic [15:0] exp_wd, w;
        logic [NB-1:0] exp_csn;
        logic [MAW-1:0] exp_a;
        acc1    = int'(c_acc[b]) + 1;
        pg1     = int'(c_pg[b]) + 1;
        pmode   = cfg_page[b] && !wr;
        exp_str = acc1 + (pmode ? 3 * pg1 : 0);
        exp_wd  = cfg_wide[b] ? wd : {8'h00, wd[7:0]};
        exp_csn = ~(4'b0001 << b);
        exp_rd  = '0;
        if (!wr) begin
            for (int k = 0; k < 4; k++) begin
                if (k == 0 || pmode) begin
                    w = model_word(b, {a[MAW-1:2], a[1:0] + 2'(k)});
                    if (!cfg_wide[b]) w[15:8] = 8'h00;
                    exp_rd[k*16 +: 16] = w;
                end
            end
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {2'(b), a}; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen_done && guard < 600) begin
            any_cs = (mem_cs_n != '1);
            stb    = wr ? !mem_we_n : !mem_oe_n;
            if (done) begin
                seen_done = 1;
            end else begin
                if (any_cs && mem_cs_n != exp_csn) cs_bad = 1;
                if (wr ? !mem_oe_n : !mem_we_n) wr_bad = 1;
                if (stb) begin
                    beat  = (n_str < acc1) ? 0 : 1 + (n_str - acc1) / pg1;
                    exp_a = {a[MAW-1:2], a[1:0] + 2'(beat)};
                    if (mem_addr != exp_a) addr_bad = 1;
                    n_str++;
                    ph = 2;
                end else if (any_cs) begin
                    if (ph < 2) n_csu++; else n_csh++;
                    if (ph == 0) ph = 1;
                end else begin
                    if (ph == 0) n_pre++; else n_ah++;
                end
                if (!stb && mem_addr != a && ph != 2 && n_str == 0) addr_bad = 1;
                if (wr && any_cs && (mem_dout_en !== 1'b1 || mem_dout !== exp_wd)) wr_bad = 1;
                if (!any_cs && mem_dout_en) wr_bad = 1;
                if (poke && guard == 1) begin req_valid = 1'b1; req_addr = {2'(b), ~a}; end
                if (poke && guard == 2) req_valid = 1'b0;
                guard++;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(seen_done, "R5", {tag, " done reached"}, 64'(seen_done), 64'd1);
        chk(n_pre == int'(c_as[b]), "R2", {tag, " address setup cycles"}, 64'(n_pre), 64'(c_as[b]));
        chk(n_csu == int'(c_cs[b]), "R3", {tag, " cs setup cycles"}, 64'(n_csu), 64'(c_cs[b]));
        chk(n_str == exp_str, pmode ? "R6" : "R4", {tag, " strobe cycles"}, 64'(n_str), 64'(exp_str));
        chk(n_csh == int'(c_ch[b]) && n_ah == int'(c_ah[b]), "R5", {tag, " cs/addr hold cycles"},
            {32'(n_csh), 32'(n_ah)}, {32'(c_ch[b]), 32'(c_ah[b])});
        chk(!cs_bad, "R10", {tag, " only addressed chip select"}, 64'(cs_bad), 64'd0);
        chk(!addr_bad, pmode ? "R6" : "R2", {tag, " address per item"}, 64'(addr_bad), 64'd0);
        if (wr) chk(!wr_bad, "R9", {tag, " write strobe and data drive"}, 64'(wr_bad), 64'd0);
        chk(rd_data == exp_rd, cfg_wide[b] ? "R7" : "R8", {tag, " read data"}, rd_data, exp_rd);
        @(negedge clk);
        chk(!done && req_ready, "R5", {tag, " done one cycle then ready"},
            {62'd0, done, req_ready}, 64'd1);
        if (poke) begin
            bit started = 0;
            for (int i = 0; i < 5; i++) begin
                if (mem_cs_n != '1 || !req_ready) started = 1;
                @(negedge clk);
            end
            chk(!started, "R11", {tag, " request while busy ignored"}, 64'(started), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) set_bank(b, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk(mem_cs_n == '1 && mem_oe_n && mem_we_n && !mem_dout_en && !done && req_ready
            && rd_data == '0, "R13", "reset outputs",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en, done, req_ready, 52'(rd_data != 0)},
            {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 52'd0});
        rst_n = 1'b1;
        @(negedge clk);

        // R12: all fields zero on bank 0, narrow read
        do_access(0, 1'b0, 10'h055, 16'h0, 1'b0, "R12 fastest");
        // R1: distinct words per bank; bank 3 must use only its own fields
        set_bank(1, 3, 2, 4, 1, 2, 2, 1'b0, 1'b1);
        set_bank(2, 1, 1, 2, 3, 1, 0, 1'b1, 1'b0);
        set_bank(3, 7, 5, 9, 6, 4, 3, 1'b0, 1'b1);
        do_access(3, 1'b0, 10'h3C1, 16'h0, 1'b0, "R1 bank3 layout");
        do_access(1, 1'b0, 10'h123, 16'h0, 1'b0, "R1 bank1 layout");
        // R6: page read with low bits starting at 2 (wraps)
        cfg_page[1] = 1'b1;
        do_access(1, 1'b0, 10'h2A6, 16'h0, 1'b0, "R6 page wrap");
        // R9/R8: narrow write with page enabled stays single
        do_access(2, 1'b1, 10'h0F0, 16'hBEEF, 1'b0, "R9 narrow write");
        do_access(1, 1'b1, 10'h011, 16'hC0DE, 1'b0, "R9 wide write");
        // Longest strobe and page fields
        set_bank(0, 15, 15, 31, 15, 15, 15, 1'b1, 1'b1);
        do_access(0, 1'b0, 10'h3FF, 16'h0, 1'b0, "R6 max page");
        // R11: request pulse during a busy access
        do_access(0, 1'b1, 10'h200, 16'h1234, 1'b1, "R11 busy poke");

        for (int it = 0; it < 48; it++) begin
            if (it % 8 == 0) begin
                for (int b = 0; b < NB; b++) begin
                    set_bank(b, $urandom_range(0, 15), $urandom_range(0, 15),
                             $urandom_range(0, 31), $urandom_range(0, 15),
                             $urandom_range(0, 15), $urandom_range(0, 15),
                             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                end
            end
            do_access($urandom_range(0, NB-1), 1'($urandom_range(0, 1)),
                      10'($urandom), 16'($urandom), 1'b0, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule